// File: doc/BRIEF.md
# SRAM PUF Stable-Cell Picker

This block picks the most dependable cells of an SRAM array to serve as physically unclonable key bits. It works over a range of single-bit SRAM cells through a plain read and write port, and it reaches the supply through a request/acknowledge handshake with an outside power manager. The block never times anything analog itself. First it asks for a series of power cycles, each with a different supply ramp rate. After each one it reads the whole range, keeps the first capture of each cell as that cell's reference value, and marks a cell unstable if any later capture disagrees with it.

Next it grades the cells that are still stable. For each retention level, from the highest minimum supply down to the lowest, it writes the inverse of every reference value into the array. It then asks the power manager to dip the supply to that level and restore it, and reads the array back. A cell that has returned to its reference value is strongly biased, and the block records the first level at which that happened. Addresses of graded stable cells are written to a non-volatile store port, the strongest first, until the requested number of key bits is reached. Only addresses are stored; no helper data is produced.

Top module: `puf_cell_picker`

## Requirements
- R1: After reset, sup_req, mem_re, mem_we, nv_we, done and shortfall are all low.
- R2: After start, the block issues RAMPS power-cycle requests in order. Each has sup_code MSB = 0 and ramp index 0, 1, 2... in the low bits. The whole range is read after each acknowledge.
- R3: A cell whose read value after any ramp differs from its value after ramp 0 is never emitted, however strong it is in retention.
- R4: Before each retention request, every cell in the range holds the inverse of its ramp-0 value. Retention requests carry sup_code MSB = 1 and level index 0, 1, 2... in the low bits, and come after all ramp requests.
- R5: A stable cell is graded with the first level index at which its readback equals its ramp-0 value. A cell that never flips back is never emitted.
- R6: Emitted entries come in ascending grade, then ascending address. nv_cell holds the cell address and nv_slot counts 0, 1, 2... for each emitted entry.
- R7: At most KEY_BITS entries are emitted per run, and nv_we is low while done is high.
- R8: done rises after the last entry and clears on the next accepted start. shortfall is high with done exactly when fewer than KEY_BITS entries were emitted.
- R9: A start pulse while a run is in progress is ignored. The request sequence does not restart.
- R10: sup_req and sup_code hold steady until sup_ack, and no array access takes place while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a selection run |
| sup_req | output | 1 | Supply action request, held until acknowledged |
| sup_code | output | STEP_W+1 | MSB: 0 ramp power cycle, 1 retention dip; low bits: ramp or level index |
| sup_ack | input | 1 | One-cycle acknowledge that the supply action is complete |
| mem_addr | output | ADDR_W | SRAM cell address |
| mem_re | output | 1 | Read strobe; mem_rdata is valid from the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 1 | Write data |
| mem_rdata | input | 1 | Read data |
| nv_we | output | 1 | Store strobe for one selected address |
| nv_slot | output | SLOT_W | Index of the entry being stored |
| nv_cell | output | ADDR_W | Address of the selected cell |
| done | output | 1 | Run finished |
| shortfall | output | 1 | Fewer cells qualified than requested |

## Verification
The assertions assume that the power manager sends sup_ack as a single-cycle pulse, only while sup_req is high. They also assume the SRAM returns read data in the cycle after mem_re and holds it. The bench's supply and memory model is a single process that pulses the acknowledge once per request after a varying delay. It answers reads at the falling edge, so data is ready before the controller samples it. Cell behaviour is set per cell by a preferred value, a retention threshold and an instability flag. The unstable cells include some with the strongest threshold, so that excluding them changes the emitted list.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_RD_ISS,
        ST_RD_TAKE,
        ST_WR,
        ST_DIP,
        ST_EMIT,
        ST_FIN
    } ssel_state_e;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_REF,
        UPD_CMP,
        UPD_GRADE
    } upd_kind_e;

    localparam logic SUP_RAMP = 1'b0;
    localparam logic SUP_DIP  = 1'b1;

    function automatic int wbits(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ssel_cellbook.sv
module ssel_cellbook
    import ssel_pkg::*;
#(
    parameter int CELLS = 16,
    parameter int LVLS  = 4,
    localparam int ADDR_W = wbits(CELLS),
    localparam int LVL_W  = wbits(LVLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  upd_kind_e         upd_kind,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_bit,
    input  logic [LVL_W-1:0]  upd_lvl,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_ref,
    output logic              look_ok,
    output logic [LVL_W-1:0]  look_grade
);

    logic             ref_q    [CELLS];
    logic             bad_q    [CELLS];
    logic             graded_q [CELLS];
    logic [LVL_W-1:0] grade_q  [CELLS];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < CELLS; i++) begin
                ref_q[i]    <= 1'b0;
                bad_q[i]    <= 1'b0;
                graded_q[i] <= 1'b0;
                grade_q[i]  <= '0;
            end
        end else begin
            case (upd_kind)
                UPD_REF: begin
                    ref_q[upd_addr]    <= upd_bit;
                    bad_q[upd_addr]    <= 1'b0;
                    graded_q[upd_addr] <= 1'b0;
                end
                UPD_CMP: begin
                    if (upd_bit != ref_q[upd_addr])
                        bad_q[upd_addr] <= 1'b1;
                end
                UPD_GRADE: begin
                    if (!bad_q[upd_addr] && !graded_q[upd_addr] &&
                        upd_bit == ref_q[upd_addr]) begin
                        graded_q[upd_addr] <= 1'b1;
                        grade_q[upd_addr]  <= upd_lvl;
                    end
                end
                default: ;
            endcase
        end
    end

    assign look_ref   = ref_q[look_addr];
    assign look_ok    = graded_q[look_addr] & ~bad_q[look_addr];
    assign look_grade = grade_q[look_addr];

    logic [CELLS-1:0] bad_vec, graded_vec;
    always_comb begin
        for (int i = 0; i < CELLS; i++) begin
            bad_vec[i]    = bad_q[i];
            graded_vec[i] = graded_q[i];
        end
    end

    // R3: an unstable mark is never withdrawn within a run
    a_r3_bad_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (($past(bad_vec) & ~bad_vec) == '0));

    // R5: a grade is only ever granted to a stable cell
    a_r5_grade_stable_only: assert property (@(posedge clk) disable iff (rst)
        (graded_vec & bad_vec) == '0);

endmodule

// File: rtl/ssel_seq.sv
module ssel_seq
    import ssel_pkg::*;
#(
    parameter int CELLS    = 16,
    parameter int RAMPS    = 3,
    parameter int LVLS     = 4,
    parameter int KEY_BITS = 6,
    localparam int ADDR_W = wbits(CELLS),
    localparam int LVL_W  = wbits(LVLS),
    localparam int STEP_W = wbits(maxi(RAMPS, LVLS)),
    localparam int SLOT_W = wbits(KEY_BITS),
    localparam int CNT_W  = $clog2(KEY_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              sup_req,
    output logic [STEP_W:0]   sup_code,
    input  logic              sup_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic              mem_wdata,
    input  logic              mem_rdata,
    output logic              book_clr,
    output upd_kind_e         upd_kind,
    output logic [ADDR_W-1:0] upd_addr,
    output logic              upd_bit,
    output logic [LVL_W-1:0]  upd_lvl,
    output logic [ADDR_W-1:0] look_addr,
    input  logic              look_ref,
    input  logic              look_ok,
    input  logic [LVL_W-1:0]  look_grade,
    output logic              nv_we,
    output logic [SLOT_W-1:0] nv_slot,
    output logic [ADDR_W-1:0] nv_cell,
    output logic              done,
    output logic              shortfall
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CELLS - 1);
    localparam logic [STEP_W-1:0] LAST_RAMP = STEP_W'(RAMPS - 1);
    localparam logic [STEP_W-1:0] LAST_LVL  = STEP_W'(LVLS - 1);
    localparam logic [LVL_W-1:0]  LAST_ELVL = LVL_W'(LVLS - 1);
    localparam logic [CNT_W-1:0]  KEY_CNT   = CNT_W'(KEY_BITS);

    ssel_state_e       state_q;
    logic              in_ret_q;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LVL_W-1:0]  elvl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              hit;

    assign hit = (state_q == ST_EMIT) && look_ok &&
                 (look_grade == elvl_q) && (cnt_q < KEY_CNT);

    always_comb begin
        sup_req   = (state_q == ST_PWR) || (state_q == ST_DIP);
        sup_code  = {(state_q == ST_DIP) ? SUP_DIP : SUP_RAMP, step_q};
        mem_addr  = addr_q;
        mem_re    = (state_q == ST_RD_ISS);
        mem_we    = (state_q == ST_WR);
        mem_wdata = ~look_ref;
        book_clr  = (state_q == ST_IDLE) && start;
        upd_kind  = UPD_NONE;
        if (state_q == ST_RD_TAKE) begin
            if (in_ret_q)            upd_kind = UPD_GRADE;
            else if (step_q == '0)   upd_kind = UPD_REF;
            else                     upd_kind = UPD_CMP;
        end
        upd_addr  = addr_q;
        upd_bit   = mem_rdata;
        upd_lvl   = LVL_W'(step_q);
        look_addr = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            in_ret_q  <= 1'b0;
            step_q    <= '0;
            addr_q    <= '0;
            elvl_q    <= '0;
            cnt_q     <= '0;
            nv_we     <= 1'b0;
            nv_slot   <= '0;
            nv_cell   <= '0;
            done      <= 1'b0;
            shortfall <= 1'b0;
        end else begin
            nv_we <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        in_ret_q  <= 1'b0;
                        step_q    <= '0;
                        addr_q    <= '0;
                        done      <= 1'b0;
                        shortfall <= 1'b0;
                        state_q   <= ST_PWR;
                    end
                end
                ST_PWR, ST_DIP: begin
                    if (sup_ack) begin
                        addr_q  <= '0;
                        state_q <= ST_RD_ISS;
                    end
                end
                ST_RD_ISS: state_q <= ST_RD_TAKE;
                ST_RD_TAKE: begin
                    addr_q <= addr_q + 1'b1;
                    if (addr_q != LAST_ADDR) begin
                        state_q <= ST_RD_ISS;
                    end else if (!in_ret_q) begin
                        if (step_q == LAST_RAMP) begin
                            in_ret_q <= 1'b1;
                            step_q   <= '0;
                            addr_q   <= '0;
                            state_q  <= ST_WR;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= ST_PWR;
                        end
                    end else if (step_q == LAST_LVL) begin
                        addr_q  <= '0;
                        elvl_q  <= '0;
                        cnt_q   <= '0;
                        state_q <= ST_EMIT;
                    end else begin
                        step_q  <= step_q + 1'b1;
                        addr_q  <= '0;
                        state_q <= ST_WR;
                    end
                end
                ST_WR: begin
                    addr_q <= addr_q + 1'b1;
                    if (addr_q == LAST_ADDR) state_q <= ST_DIP;
                end
                ST_EMIT: begin
                    if (hit) begin
                        nv_we   <= 1'b1;
                        nv_slot <= SLOT_W'(cnt_q);
                        nv_cell <= addr_q;
                        cnt_q   <= cnt_q + 1'b1;
                    end
                    if (hit && (cnt_q == KEY_CNT - 1'b1)) begin
                        state_q <= ST_FIN;
                    end else if (addr_q == LAST_ADDR) begin
                        addr_q <= '0;
                        if (elvl_q == LAST_ELVL) state_q <= ST_FIN;
                        else                     elvl_q  <= elvl_q + 1'b1;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    done      <= 1'b1;
                    shortfall <= (cnt_q < KEY_CNT);
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: a pending supply request keeps its code until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (sup_req && !sup_ack) |=> (sup_req && $stable(sup_code)));

    // R10: the array is left alone while the supply is being changed
    a_r10_quiet_array: assert property (@(posedge clk) disable iff (rst)
        sup_req |-> (!mem_re && !mem_we));

    // R7: nothing is stored once the run has finished
    a_r7_no_store_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !nv_we);

    // R8: shortfall is only ever reported with done
    a_r8_short_with_done: assert property (@(posedge clk) disable iff (rst)
        shortfall |-> done);

    // R9: start is not accepted while the run is busy
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (sup_req && start) |=> (sup_req || $past(sup_ack)));

endmodule

// File: rtl/puf_cell_picker.sv
module puf_cell_picker
    import ssel_pkg::*;
#(
    parameter int CELLS    = 16,
    parameter int RAMPS    = 3,
    parameter int LVLS     = 4,
    parameter int KEY_BITS = 6,
    localparam int ADDR_W = wbits(CELLS),
    localparam int LVL_W  = wbits(LVLS),
    localparam int STEP_W = wbits(maxi(RAMPS, LVLS)),
    localparam int SLOT_W = wbits(KEY_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              sup_req,
    output logic [STEP_W:0]   sup_code,
    input  logic              sup_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic              mem_wdata,
    input  logic              mem_rdata,
    output logic              nv_we,
    output logic [SLOT_W-1:0] nv_slot,
    output logic [ADDR_W-1:0] nv_cell,
    output logic              done,
    output logic              shortfall
);

    logic              book_clr;
    upd_kind_e         upd_kind;
    logic [ADDR_W-1:0] upd_addr;
    logic              upd_bit;
    logic [LVL_W-1:0]  upd_lvl;
    logic [ADDR_W-1:0] look_addr;
    logic              look_ref;
    logic              look_ok;
    logic [LVL_W-1:0]  look_grade;

    ssel_seq #(
        .CELLS(CELLS), .RAMPS(RAMPS), .LVLS(LVLS), .KEY_BITS(KEY_BITS)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .sup_req(sup_req), .sup_code(sup_code), .sup_ack(sup_ack),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .book_clr(book_clr), .upd_kind(upd_kind), .upd_addr(upd_addr),
        .upd_bit(upd_bit), .upd_lvl(upd_lvl), .look_addr(look_addr),
        .look_ref(look_ref), .look_ok(look_ok), .look_grade(look_grade),
        .nv_we(nv_we), .nv_slot(nv_slot), .nv_cell(nv_cell),
        .done(done), .shortfall(shortfall)
    );

    ssel_cellbook #(
        .CELLS(CELLS), .LVLS(LVLS)
    ) u_book (
        .clk(clk), .rst(rst), .clr(book_clr),
        .upd_kind(upd_kind), .upd_addr(upd_addr), .upd_bit(upd_bit),
        .upd_lvl(upd_lvl), .look_addr(look_addr), .look_ref(look_ref),
        .look_ok(look_ok), .look_grade(look_grade)
    );

    // R6: the stored slot index never reaches the requested count
    a_r6_slot_range: assert property (@(posedge clk) disable iff (rst)
        nv_we |-> (int'(nv_slot) < KEY_BITS));

endmodule

// File: tb/test_puf_cell_picker.sv
module test_puf_cell_picker;

    localparam int CELLS = 16, RAMPS = 3, LVLS = 4, KEY = 6;
    localparam int ADDR_W = 4, STEP_W = 2, SLOT_W = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1, start = 1'b0;
    logic              sup_req, sup_ack = 1'b0;
    logic [STEP_W:0]   sup_code;
    logic [ADDR_W-1:0] mem_addr, nv_cell;
    logic              mem_re, mem_we, mem_wdata, mem_rdata = 1'b0;
    logic              nv_we, done, shortfall;
    logic [SLOT_W-1:0] nv_slot;

    puf_cell_picker #(.CELLS(CELLS), .RAMPS(RAMPS), .LVLS(LVLS), .KEY_BITS(KEY)) i_puf_cell_picker (
        .clk(clk), .rst(rst), .start(start),
        .sup_req(sup_req), .sup_code(sup_code), .sup_ack(sup_ack),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .nv_we(nv_we), .nv_slot(nv_slot), .nv_cell(nv_cell),
        .done(done), .shortfall(shortfall)
    );

    int n_chk = 0, n_bad = 0;
    bit pref [CELLS];
    bit unst [CELLS];
    int thr  [CELLS];
    bit mem  [CELLS];
    int exp_q [$];
    int sup_seen = 0, run_base = 0, emitted = 0;
    bit access_bad = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: sets up the cell model and pushes the expected ranking
    task automatic setup(input int scen);
        exp_q.delete();
        for (int c = 0; c < CELLS; c++) begin
            pref[c] = bit'(c & 1) ^ bit'((c >> 2) & 1);
            thr[c]  = c % 5;
            unst[c] = (scen == 0) ? (c == 1 || c == 5 || c == 9) : (c < 12);
        end
        for (int l = 0; l < LVLS; l++)
            for (int c = 0; c < CELLS; c++)
                if (!unst[c] && thr[c] == l && exp_q.size() < KEY)
                    exp_q.push_back(c);
    endtask

    // supply manager and SRAM model
    initial begin
        forever begin
            @(negedge clk);
            sup_ack = 1'b0;
            if (mem_we) mem[mem_addr] = mem_wdata;
            if (mem_re) mem_rdata = mem[mem_addr];
            if (sup_req) begin
                int k, idx;
                bit kind, ok;
                k    = sup_seen - run_base;
                kind = (k >= RAMPS);
                idx  = kind ? k - RAMPS : k;
                chk(sup_code[STEP_W] == kind, kind ? "R4 kind" : "R2 kind", int'(sup_code[STEP_W]), int'(kind));
                chk(int'(sup_code[STEP_W-1:0]) == idx, kind ? "R4 level" : "R2 ramp", int'(sup_code[STEP_W-1:0]), idx);
                if (kind) begin
                    ok = 1'b1;
                    for (int c = 0; c < CELLS; c++) if (mem[c] != !pref[c]) ok = 1'b0;
                    chk(ok, "R4 inverse written", int'(ok), 1);
                end
                repeat (2 + sup_seen % 3) begin
                    @(negedge clk);
                    if (mem_re || mem_we || !sup_req) access_bad = 1'b1;
                end
                for (int c = 0; c < CELLS; c++) begin
                    if (!kind) mem[c] = pref[c] ^ (unst[c] && idx == 1);
                    else if (idx >= thr[c]) mem[c] = pref[c];
                end
                sup_seen++;
                sup_ack = 1'b1;
            end
        end
    end

    // monitor: pops expected entries as the design stores them
    initial begin
        forever begin
            @(negedge clk);
            if (nv_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 extra entry", int'(nv_cell), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(nv_cell) == e, "R6 R3 R5 cell order", int'(nv_cell), e);
                end
                emitted++;
            end
        end
    end

    initial begin
        int exp_n, ebase, wd;
        bit wd_ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sup_req && !mem_re && !mem_we && !nv_we && !done && !shortfall,
            "R1 reset state", int'({sup_req, mem_re, mem_we, nv_we, done, shortfall}), 0);

        for (int scen = 0; scen < 2; scen++) begin
            setup(scen);
            exp_n    = exp_q.size();
            run_base = sup_seen;
            ebase    = emitted;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(!done, "R8 done cleared by start", int'(done), 0);
            repeat (60) @(negedge clk);
            start = 1'b1;                // R9: pulse in mid-run
            @(negedge clk);
            start = 1'b0;
            wd = 0;
            while (!done && wd < 20000) begin
                @(negedge clk);
                wd++;
            end
            wd_ok = done;
            chk(wd_ok, "watchdog", wd, 20000);
            @(negedge clk);
            chk(exp_q.size() == 0, "R6 entries missing", exp_q.size(), 0);
            chk(emitted - ebase == exp_n, "R7 entry count", emitted - ebase, exp_n);
            chk(shortfall == (exp_n < KEY), "R8 shortfall", int'(shortfall), int'(exp_n < KEY));
            chk(sup_seen - run_base == RAMPS + LVLS, "R9 request count", sup_seen - run_base, RAMPS + LVLS);
            chk(!access_bad, "R10 quiet during request", int'(access_bad), 0);
            repeat (5) @(negedge clk);
            chk(done && !nv_we, "R7 idle after done", int'({done, nv_we}), 2);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // tracks the slot index of each stored entry separately (R6)
    int slot_seen = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (start && !sup_req && !mem_re && !mem_we) slot_seen = 0;
            if (nv_we) begin
                chk(int'(nv_slot) == slot_seen, "R6 slot", int'(nv_slot), slot_seen);
                slot_seen++;
            end
        end
    end

endmodule